// File: doc/BRIEF.md
# Multi-word DMA strobe timing generator

This block paces one burst of an ATA-style multi-word DMA transfer. A requester presents a direction and a word count together with a packed 32-bit timing word for the target device. When the controller is idle and the word selects multi-word operation, it accepts the request. It captures the timing it needs and pulls the active-low acknowledge low for the length of the burst. It then runs one setup phase, and for each word a strobe pulse phase followed by a recovery phase. A one-clock done pulse closes the burst.

Each programmed 4-bit timing field gives a phase that lasts the field value plus one system clock. Read and write each have their own pulse and recovery counts, and the two directions share one setup count. The timing word is sampled only when a request is accepted, so software may rewrite it for the next device while a burst is running. A request whose word count is zero gives no strobes, only the done pulse.

Top module: `mwdma_strobe_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, acknowledge, read strobe and write strobe are high and done is low.
- R2: A request that arrives while timing word bit 20 is 1 (Ultra DMA select) is ignored. The outputs stay in the idle state.
- R3: The acknowledge goes low on the clock after a request is accepted. It then stays low with both strobes high for (bits 3:0 + 1) clocks, once per burst.
- R4: For a write (req_is_write = 1), each word drives wr_n low for (bits 7:4 + 1) clocks while rd_n stays high.
- R5: After each write pulse, both strobes stay high for (bits 11:8 + 1) clocks of write recovery.
- R6: For a read (req_is_write = 0), each word drives rd_n low for (bits 15:12 + 1) clocks while wr_n stays high.
- R7: After each read pulse, both strobes stay high for (bits 19:16 + 1) clocks of read recovery.
- R8: During a burst of N words the acknowledge stays low throughout, exactly N pulse/recovery pairs occur, and the two strobes are never low together.
- R9: After the last recovery phase the acknowledge goes high and done is high for exactly one clock. The controller then returns to idle and can accept the next request.
- R10: The timing word is captured at acceptance. Changing it during a burst, or raising new requests during a burst, changes nothing in the burst in progress.
- R11: A request with word count 0 gives no acknowledge and no strobes, and done is high for one clock on the clock after acceptance.
- R12: Timing word bits 31:21 (clock-rate select, format bit, reserved) have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all phase lengths count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request to start a burst; sampled only while idle |
| req_is_write | input | 1 | 1 = write burst, 0 = read burst |
| req_count | input | CNT_W | Number of words in the burst |
| cfg_word | input | 32 | Packed per-device timing word |
| dack_n | output | 1 | Active-low DMA acknowledge, low for the whole burst |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse when a burst (or zero-length request) ends |

## Verification
The hardest case to reach is a change to the timing word, together with fresh requests, that lands in the middle of a burst. The captured copy must hold for every remaining phase, and the extra request must not restart the sequence. The bench drives a burst with one preset. Partway through it swaps the word for another preset and pulses new requests. It also holds a request high across the done cycle, so the next burst starts on the first idle clock. A behavioural queue model, built only when a request is accepted, predicts every output on every clock.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

  localparam int unsigned FIELD_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_RECOV = 3'd3,
    ST_DONE  = 3'd4
  } phase_e;

  typedef struct packed {
    logic               udma;
    logic [FIELD_W-1:0] setup;
    logic [FIELD_W-1:0] wr_pulse;
    logic [FIELD_W-1:0] wr_recov;
    logic [FIELD_W-1:0] rd_pulse;
    logic [FIELD_W-1:0] rd_recov;
  } timing_t;

endpackage

// File: rtl/mwdma_cfg_decode.sv
module mwdma_cfg_decode
  import mwdma_pkg::*;
(
  input  logic [31:0] cfg,
  output timing_t     tim
);
  // Field positions are fixed by the timing word layout.
  localparam int unsigned SEL_BIT = 20;

  logic unused_hi_bits;
  assign unused_hi_bits = ^cfg[31:SEL_BIT+1];

  always_comb begin
    tim.udma     = cfg[SEL_BIT];
    tim.setup    = cfg[3:0];
    tim.wr_pulse = cfg[7:4];
    tim.wr_recov = cfg[11:8];
    tim.rd_pulse = cfg[15:12];
    tim.rd_recov = cfg[19:16];
  end

endmodule

// File: rtl/mwdma_phase_timer.sv
module mwdma_phase_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: a loaded count walks down by one per clock until zero
  assert_timer_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/mwdma_burst_seq.sv
module mwdma_burst_seq
  import mwdma_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_is_write,
  input  logic [CNT_W-1:0]   req_count,
  input  timing_t            tim,
  input  logic               tmr_expired,
  output logic               tmr_load,
  output logic [FIELD_W-1:0] tmr_val,
  output logic               dack_n,
  output logic               rd_n,
  output logic               wr_n,
  output logic               done
);
  phase_e             state, nxt;
  logic               dir_wr_q;
  logic [FIELD_W-1:0] pulse_q, recov_q;
  logic [CNT_W-1:0]   words_left;
  logic               accept;

  assign accept = (state == ST_IDLE) && req_valid && !tim.udma;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (req_count == '0) nxt = ST_DONE;
        else begin
          nxt      = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = tim.setup;
        end
      end
      ST_SETUP: if (tmr_expired) begin
        nxt      = ST_PULSE;
        tmr_load = 1'b1;
        tmr_val  = pulse_q;
      end
      ST_PULSE: if (tmr_expired) begin
        nxt      = ST_RECOV;
        tmr_load = 1'b1;
        tmr_val  = recov_q;
      end
      ST_RECOV: if (tmr_expired) begin
        if (words_left == CNT_W'(1)) nxt = ST_DONE;
        else begin
          nxt      = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = pulse_q;
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      dir_wr_q   <= 1'b0;
      pulse_q    <= '0;
      recov_q    <= '0;
      words_left <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        dir_wr_q   <= req_is_write;
        pulse_q    <= req_is_write ? tim.wr_pulse : tim.rd_pulse;
        recov_q    <= req_is_write ? tim.wr_recov : tim.rd_recov;
        words_left <= req_count;
      end else if (state == ST_RECOV && tmr_expired) begin
        words_left <= words_left - 1'b1;
      end
    end
  end

  // Registered outputs derived from the next phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      dack_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      done   <= 1'b0;
    end else begin
      dack_n <= !(nxt == ST_SETUP || nxt == ST_PULSE || nxt == ST_RECOV);
      rd_n   <= !(nxt == ST_PULSE && !dir_wr_q);
      wr_n   <= !(nxt == ST_PULSE && dir_wr_q);
      done   <= (nxt == ST_DONE);
    end
  end

  // R2: a request with the Ultra DMA select set leaves the controller idle
  assert_udma_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && req_valid && tim.udma) |=> (state == ST_IDLE));

  // R8: strobes never overlap and only occur under acknowledge
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  assert_strobe_in_dack_R8: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !dack_n);

  // R9: done is a single clock with acknowledge released
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_dack_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> dack_n);

endmodule

// File: rtl/mwdma_strobe_gen.sv
module mwdma_strobe_gen
  import mwdma_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_is_write,
  input  logic [CNT_W-1:0] req_count,
  input  logic [31:0]      cfg_word,
  output logic             dack_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             done
);
  timing_t            tim;
  logic               tmr_load;
  logic [FIELD_W-1:0] tmr_val;
  logic               tmr_expired;

  mwdma_cfg_decode u_decode (
    .cfg (cfg_word),
    .tim (tim)
  );

  mwdma_phase_timer #(.W(FIELD_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  mwdma_burst_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_is_write (req_is_write),
    .req_count    (req_count),
    .tim          (tim),
    .tmr_expired  (tmr_expired),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .dack_n       (dack_n),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .done         (done)
  );

endmodule

// File: tb/mwdma_strobe_gen_tb.sv
module mwdma_strobe_gen_tb;
  localparam int CNT_W = 16;
  localparam logic [31:0] P_M0 = 32'h7F0FFFF3;
  localparam logic [31:0] P_M1 = 32'h7F035352;
  localparam logic [31:0] P_M2 = 32'h7F024241;
  localparam logic [31:0] P_U0 = 32'h7F7436A1;
  localparam logic [31:0] P_M2_HI = 32'hFFE24241; // bits 31:21 set, bit 20 clear

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 1'b0, req_is_write = 1'b0;
  logic [CNT_W-1:0] req_count = '0;
  logic [31:0] cfg_word = P_M2;
  logic dack_n, rd_n, wr_n, done;

  mwdma_strobe_gen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_write(req_is_write),
    .req_count(req_count), .cfg_word(cfg_word),
    .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n), .done(done)
  );

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  string scen = "R1";
  logic [3:0] q_exp[$];   // {dack_n, rd_n, wr_n, done}
  string      q_tag[$];

  // Expected waveform, built only when a request is accepted.
  function automatic void push_n(int n, logic [3:0] v, string tag);
    for (int i = 0; i < n; i++) begin
      q_exp.push_back(v);
      q_tag.push_back(tag);
    end
  endfunction

  function automatic void build(bit w, int n, logic [31:0] c);
    int s  = int'(c[3:0]) + 1;
    int wp = int'(c[7:4]) + 1;
    int wr = int'(c[11:8]) + 1;
    int rp = int'(c[15:12]) + 1;
    int rr = int'(c[19:16]) + 1;
    if (n == 0) begin
      push_n(1, 4'b1111, {"R11 ", scen});
      return;
    end
    push_n(s, 4'b0110, {"R3 ", scen});
    for (int k = 0; k < n; k++) begin
      if (w) begin
        push_n(wp, 4'b0100, {"R4 ", scen});
        push_n(wr, 4'b0110, {"R5 ", scen});
      end else begin
        push_n(rp, 4'b0010, {"R6 ", scen});
        push_n(rr, 4'b0110, {"R7 ", scen});
      end
    end
    push_n(1, 4'b1111, {"R9 ", scen});
  endfunction

  task automatic step(input bit r, input bit v, input bit w, input int n,
                      input logic [31:0] c);
    logic [3:0] got, exp;
    string tag;
    bit idle_now;
    @(negedge clk);
    got = {dack_n, rd_n, wr_n, done};
    if (q_exp.size() > 0) begin
      exp = q_exp.pop_front();
      tag = q_tag.pop_front();
      idle_now = 1'b0;
    end else begin
      exp = 4'b1110;
      tag = {"idle ", scen};
      idle_now = 1'b1;
    end
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s t=%0t got=%b exp=%b (dack_n,rd_n,wr_n,done)",
               tag, $time, got, exp);
    end
    rst = r; req_valid = v; req_is_write = w;
    req_count = CNT_W'(n); cfg_word = c;
    if (r) begin
      q_exp.delete();
      q_tag.delete();
    end else if (idle_now && v && !c[20]) begin
      build(w, n, c);
    end
  endtask

  task automatic idle(input int k, input logic [31:0] c);
    for (int i = 0; i < k; i++) step(1'b0, 1'b0, 1'b0, 0, c);
  endtask

  initial begin
    // R1: reset state, held and released
    scen = "R1";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 0, P_M2);
    idle(3, P_M2);

    // R4 R5 R8 R9: three-word write with mode 2 preset
    scen = "R8 wr3 m2";
    step(1'b0, 1'b1, 1'b1, 3, P_M2);
    idle(40, P_M2);

    // R6 R7: two-word read with mode 0 preset (long phases)
    scen = "R6 rd2 m0";
    step(1'b0, 1'b1, 1'b0, 2, P_M0);
    idle(80, P_M0);

    // R2: Ultra DMA select, request ignored
    scen = "R2";
    step(1'b0, 1'b1, 1'b1, 4, P_U0);
    step(1'b0, 1'b1, 1'b0, 2, P_U0);
    idle(10, P_U0);

    // R11: zero word count
    scen = "R11";
    step(1'b0, 1'b1, 1'b1, 0, P_M2);
    idle(5, P_M2);

    // R10: timing word swapped and extra requests during a burst
    scen = "R10";
    step(1'b0, 1'b1, 1'b0, 2, P_M1);
    idle(5, P_M1);
    step(1'b0, 1'b1, 1'b1, 5, P_M0);
    idle(3, P_M0);
    step(1'b0, 1'b1, 1'b1, 0, P_M2);
    idle(40, P_M0);

    // R12: high bits set, must match the plain mode 2 timing
    scen = "R12";
    step(1'b0, 1'b1, 1'b0, 2, P_M2_HI);
    idle(30, P_M2_HI);
    step(1'b0, 1'b1, 1'b1, 1, P_M2_HI);
    idle(20, P_M2_HI);

    // R9: request held high across done, back-to-back bursts with mode 1
    scen = "R9 b2b m1";
    for (int i = 0; i < 70; i++) step(1'b0, 1'b1, 1'b1, 2, P_M1);
    idle(40, P_M1);

    // R1: reset in the middle of a burst
    scen = "R1 midburst";
    step(1'b0, 1'b1, 1'b0, 3, P_M0);
    idle(12, P_M0);
    step(1'b1, 1'b0, 1'b0, 0, P_M0);
    step(1'b1, 1'b0, 1'b0, 0, P_M0);
    idle(6, P_M0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at t=%0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule